// File: doc/BRIEF.md
# UART Channel Interrupt Enable and Arbitration Unit

This unit sits between the event sources of one UART channel and the channel's single interrupt line. It collects events from the receiver (data level, line status, 9th-bit address flag, special-character match), the transmitter (holding register empty), the modem-status logic and the RTS/CTS flow-control logic. It keeps a CPU-written 8-bit enable register and reports the highest-ranked enabled pending source as a 4-bit identifier. It also raises a sleep request that may gate the channel clock when nothing is pending.

The meaning of several enable bits depends on the operating mode. With 9-bit framing, the address-bit event joins the receiver-status source and bit 5 enables special-character matches. Without 9-bit framing but with enhanced mode, bit 5 enables XOFF and XOFF2 detection. In the legacy mode selected by the 750-compatibility input, with neither 9-bit framing nor enhanced mode, bit 5 acts as a second sleep bit. Bits 6 and 7 gate the RTS and CTS sources only in enhanced mode; outside it those sources are always enabled.

Top module: `uart_irq_ctrl`

## Requirements
- R1: When `rst_n` is low at a clock edge, the enable register, all pending flags and the sleep request are cleared, so `irq`=0 and `irq_id`=4'h1.
- R2: When `ier_wr` is high at a clock edge, `ier_q` takes `ier_wdata` at that edge.
- R3: While `rx_level_ok`=1 and enable bit 0 is set, the receive-data source is active with `irq_id`=4'h4. It is not latched and goes inactive as soon as `rx_level_ok` falls.
- R4: `rx_status_evt` latches the receiver-status source, and so does `addr_bit_evt`, but only while `nine_bit`=1. The source is gated by enable bit 2, reports `irq_id`=4'h6 and is cleared by `lsr_rd`. With `nine_bit`=0, `addr_bit_evt` has no effect.
- R5: `thr_empty_evt` latches the transmitter-empty source. It is gated by enable bit 1, reports 4'h2, and is cleared by `thr_wr` or by `iid_rd` in a cycle where it is the reported source.
- R6: `modem_evt` latches the modem-status source. It is gated by enable bit 3, reports 4'h0, and is cleared by `msr_rd`.
- R7: The special-character source reports 4'h8 and is cleared by `iid_rd` while it is reported. It is latched from `spec_match_evt` when `nine_bit`=1. It is latched from `xoff_evt` (with `xoff_fc_en`=1) or `xoff2_evt` (with `xoff2_en`=1) when `nine_bit`=0 and `enhanced`=1. It is gated by enable bit 5 and never latched or active when both `nine_bit` and `enhanced` are 0.
- R8: `rts_evt` and `cts_evt` latch the flow-control source, which reports 4'hA and is cleared by `iid_rd` while it is reported. With `enhanced`=1, RTS is gated by enable bit 6 and CTS by bit 7. With `enhanced`=0, both are always enabled.
- R9: When several enabled sources are pending, `irq_id` reports the first of: receiver status, receive data, transmitter empty, modem status, special character, flow control. With none, it reports 4'h1.
- R10: `sleep_req`=1 exactly when no enabled source is pending and a sleep bit is set. The sleep bits are enable bit 4 and, when `nine_bit`=0, `enhanced`=0 and `compat750`=1, enable bit 5.
- R11: A source that becomes pending while its enable bit is clear stays latched and raises `irq` once the bit is set. A set event in the same cycle as a clear leaves the source pending.
- R12: `irq`=1 exactly when `irq_id` differs from 4'h1, with no further output gating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| nine_bit | input | 1 | 9-bit framing active |
| enhanced | input | 1 | Enhanced mode active |
| compat750 | input | 1 | 750-compatible legacy mode selected |
| xoff_fc_en | input | 1 | In-band flow control configured (XOFF detection) |
| xoff2_en | input | 1 | XOFF2 detection enabled |
| rx_level_ok | input | 1 | Receive FIFO at or above trigger level |
| rx_status_evt | input | 1 | Receiver line-status event pulse |
| addr_bit_evt | input | 1 | Character with 9th bit set received |
| thr_empty_evt | input | 1 | Transmit holding register became empty |
| modem_evt | input | 1 | Modem-status change pulse |
| spec_match_evt | input | 1 | Special-character match (9-bit framing) |
| xoff_evt | input | 1 | XOFF character received |
| xoff2_evt | input | 1 | XOFF2 character received |
| rts_evt | input | 1 | RTS flow-control event |
| cts_evt | input | 1 | CTS flow-control event |
| lsr_rd | input | 1 | Line-status register read |
| msr_rd | input | 1 | Modem-status register read |
| iid_rd | input | 1 | Interrupt identifier read |
| thr_wr | input | 1 | Transmit holding register write |
| ier_q | output | 8 | Current enable register |
| irq | output | 1 | Interrupt request |
| irq_id | output | 4 | Identifier of highest-ranked pending source |
| sleep_req | output | 1 | Request to gate the channel clock |

## Verification
On every cycle, the assertions check four things: that `irq` and a "no interrupt" identifier never coincide, that sleep is never requested while an interrupt is raised, that set events dominate clears in every pending flag, and that a pending CTS event outside enhanced mode always raises the line. The ignored address bit outside 9-bit framing is checked at the decode stage. Mode-dependent reinterpretation of bit 5, the priority cascade as sources are drained one by one, and the clear-on-identifier-read rule can only be shown by the bench scenarios. A behavioural model compared each cycle backs them up.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int IER_W = 8;
  localparam int ID_W  = 4;
  localparam int NLAT  = 6;   // latched: rxs, thr, msr, spc, rts, cts
  localparam int NPRI  = 6;   // ranked: rxs, rxd, thr, msr, spc, fc

  localparam int L_RXS = 0;
  localparam int L_THR = 1;
  localparam int L_MSR = 2;
  localparam int L_SPC = 3;
  localparam int L_RTS = 4;
  localparam int L_CTS = 5;

  typedef enum logic [ID_W-1:0] {
    IID_MSR  = 4'h0,
    IID_NONE = 4'h1,
    IID_THR  = 4'h2,
    IID_RXD  = 4'h4,
    IID_RXS  = 4'h6,
    IID_SPC  = 4'h8,
    IID_FC   = 4'hA
  } iid_e;

  // Highest-ranked active source; index 0 wins.
  function automatic iid_e prio_pick(input logic [NPRI-1:0] act);
    iid_e r;
    if      (act[0]) r = IID_RXS;
    else if (act[1]) r = IID_RXD;
    else if (act[2]) r = IID_THR;
    else if (act[3]) r = IID_MSR;
    else if (act[4]) r = IID_SPC;
    else if (act[5]) r = IID_FC;
    else             r = IID_NONE;
    return r;
  endfunction

  // Bit 5 doubles as a sleep bit only in the plain legacy mode.
  function automatic logic sleep_bits(input logic [IER_W-1:0] ier,
                                      input logic nine, input logic enh,
                                      input logic c750);
    return ier[4] | (ier[5] & ~nine & ~enh & c750);
  endfunction
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);
  // R11
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q);
endmodule

// File: rtl/irq_mode_decode.sv
module irq_mode_decode
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IER_W-1:0] ier,
  input  logic             nine_bit,
  input  logic             enhanced,
  input  logic             compat750,
  input  logic             xoff_fc_en,
  input  logic             xoff2_en,
  input  logic             rx_status_evt,
  input  logic             addr_bit_evt,
  input  logic             thr_empty_evt,
  input  logic             modem_evt,
  input  logic             spec_match_evt,
  input  logic             xoff_evt,
  input  logic             xoff2_evt,
  input  logic             rts_evt,
  input  logic             cts_evt,
  output logic [NLAT-1:0]  set_lat,
  output logic [NLAT-1:0]  en_lat,
  output logic             en_rxd,
  output logic             sleep_bit
);
  logic spc_mode_ok;
  logic spc_evt_enh;

  assign spc_mode_ok = nine_bit | enhanced;
  assign spc_evt_enh = (xoff_fc_en & xoff_evt) | (xoff2_en & xoff2_evt);

  always_comb begin
    set_lat        = '0;
    set_lat[L_RXS] = rx_status_evt | (nine_bit & addr_bit_evt);
    set_lat[L_THR] = thr_empty_evt;
    set_lat[L_MSR] = modem_evt;
    set_lat[L_SPC] = nine_bit ? spec_match_evt : (enhanced & spc_evt_enh);
    set_lat[L_RTS] = rts_evt;
    set_lat[L_CTS] = cts_evt;

    en_lat        = '0;
    en_lat[L_RXS] = ier[2];
    en_lat[L_THR] = ier[1];
    en_lat[L_MSR] = ier[3];
    en_lat[L_SPC] = ier[5] & spc_mode_ok;
    en_lat[L_RTS] = enhanced ? ier[6] : 1'b1;
    en_lat[L_CTS] = enhanced ? ier[7] : 1'b1;
  end

  assign en_rxd    = ier[0];
  assign sleep_bit = sleep_bits(ier, nine_bit, enhanced, compat750);

  // R4
  addr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nine_bit && !rx_status_evt) |-> !set_lat[L_RXS]);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPRI-1:0] act,
  output iid_e            id,
  output logic            any
);
  assign id  = prio_pick(act);
  assign any = |act;

  // R9
  none_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any |-> (id == IID_NONE));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_wr,
  input  logic [IER_W-1:0] ier_wdata,
  input  logic             nine_bit,
  input  logic             enhanced,
  input  logic             compat750,
  input  logic             xoff_fc_en,
  input  logic             xoff2_en,
  input  logic             rx_level_ok,
  input  logic             rx_status_evt,
  input  logic             addr_bit_evt,
  input  logic             thr_empty_evt,
  input  logic             modem_evt,
  input  logic             spec_match_evt,
  input  logic             xoff_evt,
  input  logic             xoff2_evt,
  input  logic             rts_evt,
  input  logic             cts_evt,
  input  logic             lsr_rd,
  input  logic             msr_rd,
  input  logic             iid_rd,
  input  logic             thr_wr,
  output logic [IER_W-1:0] ier_q,
  output logic             irq,
  output logic [ID_W-1:0]  irq_id,
  output logic             sleep_req
);
  logic [NLAT-1:0] set_lat;
  logic [NLAT-1:0] clr_lat;
  logic [NLAT-1:0] en_lat;
  logic [NLAT-1:0] pend_q;
  logic [NPRI-1:0] act;
  logic            en_rxd;
  logic            sleep_bit;
  logic            any_act;
  iid_e            cur_id;

  always_ff @(posedge clk) begin
    if (!rst_n)      ier_q <= '0;
    else if (ier_wr) ier_q <= ier_wdata;
  end

  irq_mode_decode u_dec (
    .clk(clk), .rst_n(rst_n), .ier(ier_q),
    .nine_bit(nine_bit), .enhanced(enhanced), .compat750(compat750),
    .xoff_fc_en(xoff_fc_en), .xoff2_en(xoff2_en),
    .rx_status_evt(rx_status_evt), .addr_bit_evt(addr_bit_evt),
    .thr_empty_evt(thr_empty_evt), .modem_evt(modem_evt),
    .spec_match_evt(spec_match_evt), .xoff_evt(xoff_evt),
    .xoff2_evt(xoff2_evt), .rts_evt(rts_evt), .cts_evt(cts_evt),
    .set_lat(set_lat), .en_lat(en_lat), .en_rxd(en_rxd),
    .sleep_bit(sleep_bit)
  );

  // Clear conditions; identifier read drains the reported source.
  always_comb begin
    clr_lat        = '0;
    clr_lat[L_RXS] = lsr_rd;
    clr_lat[L_THR] = thr_wr | (iid_rd & (cur_id == IID_THR));
    clr_lat[L_MSR] = msr_rd;
    clr_lat[L_SPC] = iid_rd & (cur_id == IID_SPC);
    clr_lat[L_RTS] = iid_rd & (cur_id == IID_FC);
    clr_lat[L_CTS] = iid_rd & (cur_id == IID_FC);
  end

  for (genvar g = 0; g < NLAT; g++) begin : g_lat
    irq_src_latch u_lat (
      .clk(clk), .rst_n(rst_n),
      .set(set_lat[g]), .clr(clr_lat[g]), .q(pend_q[g])
    );
  end

  assign act[0] = pend_q[L_RXS] & en_lat[L_RXS];
  assign act[1] = rx_level_ok & en_rxd;
  assign act[2] = pend_q[L_THR] & en_lat[L_THR];
  assign act[3] = pend_q[L_MSR] & en_lat[L_MSR];
  assign act[4] = pend_q[L_SPC] & en_lat[L_SPC];
  assign act[5] = (pend_q[L_RTS] & en_lat[L_RTS]) |
                  (pend_q[L_CTS] & en_lat[L_CTS]);

  irq_prio_enc u_pri (
    .clk(clk), .rst_n(rst_n), .act(act), .id(cur_id), .any(any_act)
  );

  assign irq       = any_act;
  assign irq_id    = cur_id;
  assign sleep_req = sleep_bit & ~any_act;

  // R12
  irq_id_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (irq_id != IID_NONE));
  // R10
  no_sleep_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sleep_req && irq));
  // R8
  cts_always_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enhanced && pend_q[L_CTS]) |-> irq);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    !rst_n |=> (ier_q == '0));
endmodule

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic ier_wr = 0;
  logic [7:0] ier_wdata = 0;
  logic nine_bit = 0, enhanced = 0, compat750 = 0, xoff_fc_en = 0, xoff2_en = 0;
  logic rx_level_ok = 0, rx_status_evt = 0, addr_bit_evt = 0, thr_empty_evt = 0;
  logic modem_evt = 0, spec_match_evt = 0, xoff_evt = 0, xoff2_evt = 0;
  logic rts_evt = 0, cts_evt = 0, lsr_rd = 0, msr_rd = 0, iid_rd = 0, thr_wr = 0;
  logic [7:0] ier_q;
  logic irq, sleep_req;
  logic [3:0] irq_id;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ctrl i_uart_irq_ctrl (.*);

  // ---------------- behavioural reference model ----------------
  int m_ier = 0;
  bit m_rxs, m_thr, m_msr, m_spc, m_rts, m_cts;

  function automatic int model_id();
    bit en_rts, en_cts;
    en_rts = enhanced ? m_ier[6] : 1;
    en_cts = enhanced ? m_ier[7] : 1;
    if (m_rxs && m_ier[2]) return 6;
    if (rx_level_ok && m_ier[0]) return 4;
    if (m_thr && m_ier[1]) return 2;
    if (m_msr && m_ier[3]) return 0;
    if (m_spc && m_ier[5] && (nine_bit || enhanced)) return 8;
    if ((m_rts && en_rts) || (m_cts && en_cts)) return 10;
    return 1;
  endfunction

  function automatic int model_sleep();
    bit sb;
    sb = m_ier[4] || (m_ier[5] && !nine_bit && !enhanced && compat750);
    return (sb && model_id() == 1) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    int idn;
    bit spc_set;
    if (!rst_n) begin
      m_ier = 0; {m_rxs, m_thr, m_msr, m_spc, m_rts, m_cts} = '0;
    end else begin
      idn = model_id();
      if (nine_bit) spc_set = spec_match_evt;
      else spc_set = enhanced && ((xoff_fc_en && xoff_evt) || (xoff2_en && xoff2_evt));
      if (rx_status_evt || (nine_bit && addr_bit_evt)) m_rxs = 1; else if (lsr_rd) m_rxs = 0;
      if (thr_empty_evt) m_thr = 1; else if (thr_wr || (iid_rd && idn == 2)) m_thr = 0;
      if (modem_evt) m_msr = 1; else if (msr_rd) m_msr = 0;
      if (spc_set) m_spc = 1; else if (iid_rd && idn == 8) m_spc = 0;
      if (rts_evt) m_rts = 1; else if (iid_rd && idn == 10) m_rts = 0;
      if (cts_evt) m_cts = 1; else if (iid_rd && idn == 10) m_cts = 0;
      if (ier_wr) m_ier = ier_wdata;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison, settled after the falling edge.
  always begin
    @(negedge clk); #1;
    if (rst_n && !done) begin
      chk("R9 model id", irq_id, model_id());
      chk("R12 model irq", irq, model_id() != 1);
      chk("R10 model sleep", sleep_req, model_sleep());
      chk("R2 model ier", ier_q, m_ier);
    end
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic wr_ier(input logic [7:0] v);
    ier_wr = 1; ier_wdata = v; tick(); ier_wr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    // R1 reset state
    chk("R1 irq", irq, 0); chk("R1 id", irq_id, 1);
    chk("R1 ier", ier_q, 0); chk("R1 sleep", sleep_req, 0);

    wr_ier(8'h0F);
    chk("R2 ier", ier_q, 8'h0F);

    // R3 receive data level
    rx_level_ok = 1; tick();
    chk("R3 id", irq_id, 4); chk("R3 irq", irq, 1);
    rx_level_ok = 0; tick();
    chk("R3 drop", irq_id, 1);

    // R4 receiver status outranks data
    rx_level_ok = 1; rx_status_evt = 1; tick(); rx_status_evt = 0;
    chk("R4 id", irq_id, 6);
    lsr_rd = 1; tick(); lsr_rd = 0;
    chk("R4 cleared", irq_id, 4);
    rx_level_ok = 0;
    addr_bit_evt = 1; tick(); addr_bit_evt = 0;
    chk("R4 addr ignored", irq_id, 1);
    nine_bit = 1; addr_bit_evt = 1; tick(); addr_bit_evt = 0;
    chk("R4 addr 9bit", irq_id, 6);
    lsr_rd = 1; tick(); lsr_rd = 0; nine_bit = 0;
    chk("R4 addr clr", irq_id, 1);

    // R5 transmitter empty
    thr_empty_evt = 1; tick(); thr_empty_evt = 0;
    chk("R5 id", irq_id, 2);
    iid_rd = 1; tick(); iid_rd = 0;
    chk("R5 iid clr", irq_id, 1);
    thr_empty_evt = 1; tick(); thr_empty_evt = 0;
    thr_wr = 1; tick(); thr_wr = 0;
    chk("R5 thr_wr clr", irq_id, 1);

    // R6 modem status
    modem_evt = 1; tick(); modem_evt = 0;
    chk("R6 id", irq_id, 0); chk("R12 irq", irq, 1);
    msr_rd = 1; tick(); msr_rd = 0;
    chk("R6 clr", irq, 0);

    // R11 latched while disabled
    wr_ier(8'h00);
    modem_evt = 1; tick(); modem_evt = 0;
    chk("R11 masked", irq, 0);
    wr_ier(8'h08);
    chk("R11 unmask", irq_id, 0);
    msr_rd = 1; tick(); msr_rd = 0;

    // R7 special character
    wr_ier(8'h20); nine_bit = 1;
    spec_match_evt = 1; tick(); spec_match_evt = 0;
    chk("R7 9bit", irq_id, 8);
    iid_rd = 1; tick(); iid_rd = 0;
    chk("R7 clr", irq_id, 1);
    nine_bit = 0; enhanced = 1;
    xoff_evt = 1; tick(); xoff_evt = 0;
    chk("R7 xoff off", irq_id, 1);
    xoff_fc_en = 1; xoff_evt = 1; tick(); xoff_evt = 0;
    chk("R7 xoff", irq_id, 8);
    iid_rd = 1; tick(); iid_rd = 0;
    xoff2_en = 1; xoff2_evt = 1; tick(); xoff2_evt = 0;
    chk("R7 xoff2", irq_id, 8);
    iid_rd = 1; tick(); iid_rd = 0;
    enhanced = 0; xoff2_evt = 1; tick(); xoff2_evt = 0;
    chk("R7 legacy none", irq_id, 1);
    enhanced = 1; tick();
    chk("R7 not latched", irq_id, 1);

    // R8 RTS/CTS
    wr_ier(8'h00);
    cts_evt = 1; tick(); cts_evt = 0;
    chk("R8 enh masked", irq, 0);
    enhanced = 0; tick();
    chk("R8 legacy on", irq_id, 10);
    iid_rd = 1; tick(); iid_rd = 0;
    chk("R8 clr", irq_id, 1);
    enhanced = 1; wr_ier(8'h40);
    rts_evt = 1; tick(); rts_evt = 0;
    chk("R8 rts", irq_id, 10);
    iid_rd = 1; tick(); iid_rd = 0;

    // R10 sleep
    enhanced = 0; compat750 = 1; wr_ier(8'h20);
    chk("R10 alt sleep", sleep_req, 1);
    wr_ier(8'h10);
    chk("R10 sleep", sleep_req, 1);
    cts_evt = 1; tick(); cts_evt = 0;
    chk("R10 wake", sleep_req, 0); chk("R10 irq", irq, 1);
    iid_rd = 1; tick(); iid_rd = 0;
    chk("R10 resleep", sleep_req, 1);
    enhanced = 1; wr_ier(8'h20);
    chk("R10 enh no alt", sleep_req, 0);
    enhanced = 0; compat750 = 0; tick();
    chk("R10 650 no alt", sleep_req, 0);

    // R9 priority cascade
    wr_ier(8'hEF); enhanced = 1; nine_bit = 1;
    rx_status_evt = 1; thr_empty_evt = 1; modem_evt = 1;
    spec_match_evt = 1; rts_evt = 1; rx_level_ok = 1; tick();
    {rx_status_evt, thr_empty_evt, modem_evt, spec_match_evt, rts_evt} = '0;
    chk("R9 rxs", irq_id, 6);
    lsr_rd = 1; tick(); lsr_rd = 0;
    chk("R9 rxd", irq_id, 4);
    rx_level_ok = 0; tick();
    chk("R9 thr", irq_id, 2);
    iid_rd = 1; tick(); iid_rd = 0;
    chk("R9 msr", irq_id, 0);
    msr_rd = 1; tick(); msr_rd = 0;
    chk("R9 spc", irq_id, 8);
    iid_rd = 1; tick(); iid_rd = 0;
    chk("R9 fc", irq_id, 10);
    iid_rd = 1; tick(); iid_rd = 0;
    chk("R9 none", irq_id, 1);

    // R11 set wins over clear
    thr_empty_evt = 1; thr_wr = 1; tick(); thr_empty_evt = 0; thr_wr = 0;
    chk("R11 set wins", irq_id, 2);

    // R1 reset mid-run
    rst_n = 0; tick(); rst_n = 1;
    chk("R1 rerun ier", ier_q, 0); chk("R1 rerun irq", irq, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule